// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the master side of a serial link to an 8-bit successive-approximation converter that has a multiplexed input. A request carries an address word of 2 to 4 bits, which selects the channel and mode, and a flag that asks for a verified read. The controller then pulls chip select low and produces the serial clock by dividing the system clock. It shifts out a start bit and the address word, and it skips the converter's settling bit. It then assembles the result, which arrives most significant bit first.

When the verified read is requested, the controller keeps the clock running. The converter sends the same result a second time, least significant bit first, and reuses the bit time of its LSB. The controller compares the two copies and flags a difference. With the `SHARED` parameter set, the data line toward the converter is tri-state controlled. It can then be joined with the converter's output on one wire, and the controller drives it only during the start and address bits. Every finished frame produces a one-cycle done strobe and a result that stays held. Between frames, chip select stays high for a guard time.

Top module: `adc_serial_host`

## Requirements
- R1: Under reset `cs_n`=1, `sclk`=0, `di_oe`=0 (with `SHARED`), `rsp_done`=0 and `req_ready`=0. After reset is released, `req_ready` rises once 2*HALF_DIV system clocks have passed.
- R2: `sclk` idles low and toggles only while `cs_n` is low. The first rising edge comes HALF_DIV system clocks after `cs_n` falls.
- R3: Every high phase and every low phase of `sclk` lasts exactly HALF_DIV system clocks.
- R4: `di_out` presents a 1 at rising edge 1, which is the start bit. At rising edges 2..L+1 it presents `req_addr[L-1:0]`, most significant bit first. L is `req_alen` clamped into the range 2..ADDR_MAX.
- R5: `di_out` changes only while `sclk` is low, so it is stable across every rising edge.
- R6: The bit on `do_in` at rising edge L+2 is discarded. The bits at edges L+3..L+10 form `rsp_data`, and the first of them lands in bit 7.
- R7: If `req_dual`=1, edges L+11..L+17 carry result bits 1..7 in ascending order, with bit 0 taken from edge L+10. `rsp_mismatch`=1 exactly when this copy differs from the first one. If `req_dual`=0, `rsp_mismatch`=0.
- R8: A frame has L+10 rising edges, or L+17 with `req_dual`. `cs_n` stays low for that many times 2*HALF_DIV system clocks. `cs_n` rises together with the final falling `sclk` edge, in the same cycle as `rsp_done`.
- R9: With `SHARED`, `di_oe` is high from the fall of `cs_n` until the falling edge after the last address bit, and low at all other times.
- R10: Between two frames, `cs_n` stays high for at least 2*HALF_DIV system clocks.
- R11: A request starts a frame only when `req_valid` and `req_ready` are both high. A request made while a frame or guard time is running has no effect.
- R12: `rsp_done` is high for exactly one cycle. `rsp_data` and `rsp_mismatch` hold their values until the next `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Conversion request |
| req_addr | input | ADDR_MAX | Address word, lowest L bits used |
| req_alen | input | clog2(ADDR_MAX+1) | Address length, clamped to 2..ADDR_MAX |
| req_dual | input | 1 | Also read and compare the reversed copy |
| req_ready | output | 1 | Idle, a request is accepted now |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| di_out | output | 1 | Serial data toward the converter |
| di_oe | output | 1 | Output enable for `di_out` |
| do_in | input | 1 | Serial data from the converter |
| rsp_data | output | RES_W | Result, held |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_mismatch | output | 1 | The two copies differed |

## Verification
On the falling edge that ends the last address bit, two things happen on the shared wire at the same moment: the controller releases the line and the converter starts driving its settling bit. The bench's converter model records `di_oe` on every falling edge where it drives and on every rising edge where it samples. This is done for every address length, so an early or late release is reported. The final falling edge also coincides with the rise of chip select, the load of the result and the done strobe. The bench checks the frame length, the result and the strobe at that cycle, and it corrupts single bits of the reversed copy to show that the comparison runs on the complete second copy.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [1:0] {
        ST_GUARD = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FRAME = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_sclk_gen.sv
// Serial clock divider: produces sclk and one-cycle tick pulses for each edge.
module adc_sclk_gen #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic tick_rise,
    output logic tick_fall
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
    } gen_t;

    gen_t r_q, r_d;
    logic wrap;

    always_comb begin
        wrap = (r_q.cnt == CNT_W'(HALF_DIV - 1));
        r_d  = r_q;
        if (!run) begin
            r_d = '0;
        end else if (wrap) begin
            r_d.cnt = '0;
            r_d.lvl = ~r_q.lvl;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sclk      = r_q.lvl;
    assign tick_rise = run && wrap && !r_q.lvl;
    assign tick_fall = run && wrap && r_q.lvl;

endmodule

// File: rtl/adc_rx_capture.sv
// Collects the forward result and the reversed copy from the returning line.
module adc_rx_capture #(
    parameter int RES_W = 8,
    parameter int K_W   = 5,
    parameter int L_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             sdi,
    input  logic [K_W-1:0]   k,
    input  logic [L_W-1:0]   alen,
    output logic [RES_W-1:0] msb_word,
    output logic [RES_W-1:0] lsb_word
);

    localparam logic [K_W-1:0] FWD_LO = K_W'(2);
    localparam logic [K_W-1:0] FWD_HI = K_W'(RES_W + 1);
    localparam logic [K_W-1:0] REV_LO = K_W'(RES_W + 1);
    localparam logic [K_W-1:0] REV_HI = K_W'(2 * RES_W);

    typedef struct packed {
        logic [RES_W-1:0] fwd;
        logic [RES_W-1:0] rev;
    } cap_t;

    cap_t r_q, r_d;
    logic [K_W-1:0] rel;
    logic in_fwd, in_rev;

    // rel counts bit times after the last address bit; wraps high before it
    assign rel    = k - K_W'(alen);
    assign in_fwd = (rel >= FWD_LO) && (rel <= FWD_HI);
    assign in_rev = (rel >= REV_LO) && (rel <= REV_HI);

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d = '0;
        end else if (sample) begin
            if (in_fwd) r_d.fwd = {r_q.fwd[RES_W-2:0], sdi};
            if (in_rev) r_d.rev = {sdi, r_q.rev[RES_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign msb_word = r_q.fwd;
    assign lsb_word = r_q.rev;

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int HALF_DIV = 25,
    parameter int ADDR_MAX = 4,
    parameter int RES_W    = 8,
    parameter bit SHARED   = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_MAX-1:0]          req_addr,
    input  logic [$clog2(ADDR_MAX+1)-1:0] req_alen,
    input  logic                         req_dual,
    output logic                         req_ready,
    output logic                         cs_n,
    output logic                         sclk,
    output logic                         di_out,
    output logic                         di_oe,
    input  logic                         do_in,
    output logic [RES_W-1:0]             rsp_data,
    output logic                         rsp_done,
    output logic                         rsp_mismatch
);

    localparam int L_W     = $clog2(ADDR_MAX + 1);
    localparam int K_W     = $clog2(ADDR_MAX + 2 * RES_W + 2);
    localparam int GUARD_N = 2 * HALF_DIV;
    localparam int G_W     = $clog2(GUARD_N + 1);

    typedef struct packed {
        seq_state_e           st;
        logic [K_W-1:0]       k;
        logic                 di;
        logic [ADDR_MAX-1:0]  addr;
        logic [L_W-1:0]       alen;
        logic                 dual;
        logic [G_W-1:0]       gcnt;
        logic [RES_W-1:0]     data;
        logic                 mism;
        logic                 done;
    } host_t;

    host_t r_q, r_d;

    logic                in_frame, accept, tick_rise, tick_fall;
    logic [RES_W-1:0]    cap_fwd, cap_rev;
    logic [K_W-1:0]      last_k, nk, pos;
    logic [ADDR_MAX-1:0] addr_sh;
    logic [L_W-1:0]      len_in;

    function automatic logic [L_W-1:0] clamp_len(input logic [L_W-1:0] x);
        if (x < L_W'(2))        return L_W'(2);
        if (x > L_W'(ADDR_MAX)) return L_W'(ADDR_MAX);
        return x;
    endfunction

    assign in_frame = (r_q.st == ST_FRAME);
    assign accept   = (r_q.st == ST_IDLE) && req_valid;
    assign len_in   = clamp_len(req_alen);
    assign last_k   = r_q.dual ? K_W'(r_q.alen) + K_W'(2 * RES_W)
                               : K_W'(r_q.alen) + K_W'(RES_W + 1);
    assign nk       = r_q.k + 1'b1;
    assign pos      = K_W'(r_q.alen) - nk;
    assign addr_sh  = r_q.addr >> pos;

    adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (in_frame),
        .sclk      (sclk),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    adc_rx_capture #(.RES_W(RES_W), .K_W(K_W), .L_W(L_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .sample   (tick_rise),
        .sdi      (do_in),
        .k        (r_q.k),
        .alen     (r_q.alen),
        .msb_word (cap_fwd),
        .lsb_word (cap_rev)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_GUARD: begin
                if (r_q.gcnt == G_W'(GUARD_N - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.gcnt = '0;
                end else begin
                    r_d.gcnt = r_q.gcnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_FRAME;
                    r_d.k    = '0;
                    r_d.di   = 1'b1;
                    r_d.addr = req_addr;
                    r_d.alen = len_in;
                    r_d.dual = req_dual;
                end
            end
            ST_FRAME: begin
                if (tick_fall) begin
                    if (r_q.k == last_k) begin
                        r_d.st   = ST_GUARD;
                        r_d.gcnt = '0;
                        r_d.di   = 1'b0;
                        r_d.done = 1'b1;
                        r_d.data = cap_fwd;
                        r_d.mism = r_q.dual && (cap_rev != cap_fwd);
                    end else begin
                        r_d.k  = nk;
                        r_d.di = (nk <= K_W'(r_q.alen)) && addr_sh[0];
                    end
                end
            end
            default: r_d.st = ST_GUARD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_GUARD, default: '0};
        else        r_q <= r_d;
    end

    generate
        if (SHARED) begin : g_shared_wire
            assign di_oe = in_frame && (r_q.k <= K_W'(r_q.alen));
        end else begin : g_split_wire
            assign di_oe = 1'b1;
        end
    endgenerate

    assign req_ready    = (r_q.st == ST_IDLE);
    assign cs_n         = ~in_frame;
    assign di_out       = r_q.di;
    assign rsp_data     = r_q.data;
    assign rsp_done     = r_q.done;
    assign rsp_mismatch = r_q.mism;

endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk #(
    parameter int HALF_DIV = 25,
    parameter int RES_W    = 8,
    parameter bit SHARED   = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cs_n,
    input logic             sclk,
    input logic             di_out,
    input logic             di_oe,
    input logic [RES_W-1:0] rsp_data,
    input logic             rsp_done,
    input logic             rsp_mismatch
);

    localparam int GUARD_N = 2 * HALF_DIV;
    localparam int H_W     = $clog2(GUARD_N + 2);
    localparam int P_W     = $clog2(HALF_DIV + 2);

    logic [H_W-1:0] hi_cnt;
    logic [P_W-1:0] ph_cnt;
    logic           sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            ph_cnt    <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk;
            if (!cs_n)                          hi_cnt <= '0;
            else if (hi_cnt != H_W'(GUARD_N))   hi_cnt <= hi_cnt + 1'b1;
            if (cs_n)                           ph_cnt <= '0;
            else if (sclk != sclk_prev)         ph_cnt <= P_W'(1);
            else if (ph_cnt != P_W'(HALF_DIV + 1)) ph_cnt <= ph_cnt + 1'b1;
        end
    end

    AST_SCLK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R2

    AST_SCLK_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (sclk != sclk_prev)) |-> (ph_cnt == P_W'(HALF_DIV))); // R3

    AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !cs_n) |-> $stable(di_out)); // R5

    AST_CS_RISE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> rsp_done); // R8

    AST_CS_HIGH_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= H_W'(GUARD_N))); // R10

    AST_START_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(req_valid && req_ready)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R12

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> ($stable(rsp_data) && $stable(rsp_mismatch))); // R12

    generate
        if (SHARED) begin : g_oe_chk
            AST_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
                cs_n |-> !di_oe); // R9
        end
    endgenerate

endmodule

bind adc_serial_host adc_serial_host_chk #(
    .HALF_DIV (HALF_DIV),
    .RES_W    (RES_W),
    .SHARED   (SHARED)
) u_chk (.*);

// File: tb/adc_serial_host_tb.sv
`timescale 1ns/1ps
module adc_serial_host_tb;

    localparam int HALF    = 2;
    localparam int GUARD_N = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [3:0] req_addr;
    logic [2:0] req_alen;
    logic       req_dual;
    logic       req_ready, cs_n, sclk, di_out, di_oe;
    logic       do_line = 1'b0;
    logic [7:0] rsp_data;
    logic       rsp_done, rsp_mismatch;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    adc_serial_host #(.HALF_DIV(HALF), .ADDR_MAX(4), .RES_W(8), .SHARED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_alen(req_alen), .req_dual(req_dual), .req_ready(req_ready),
        .cs_n(cs_n), .sclk(sclk), .di_out(di_out), .di_oe(di_oe), .do_in(do_line),
        .rsp_data(rsp_data), .rsp_done(rsp_done), .rsp_mismatch(rsp_mismatch)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fval(input int a, input int s);
        return 8'(a * 29 + s * 7 + 3);
    endfunction

    // converter model, written by the main process between frames only
    int         m_len  = 2;
    int         m_seed = 0;
    logic [7:0] m_mask = 8'h00;

    // converter model state
    logic       sclk_prev = 1'b0;
    logic       cs_prev   = 1'b1;
    int         ph = 0, acnt = 0, oc = 0, rises = 0, start_at = 0, oe_err = 0;
    logic [3:0] raddr = '0;
    logic [7:0] mv = '0;
    logic [7:0] mvx;

    always @(sclk or cs_n) begin
        if (cs_prev && !cs_n) begin
            ph = 0; acnt = 0; oc = 0; rises = 0; start_at = 0; oe_err = 0;
            raddr = '0; do_line = 1'b0;
        end else if (!cs_n && sclk && !sclk_prev) begin
            rises++;
            if (ph < 2 && di_oe !== 1'b1) oe_err++;
            if (ph == 0) begin
                if (di_out) begin ph = 1; start_at = rises; end
            end else if (ph == 1) begin
                raddr = {raddr[2:0], di_out};
                acnt++;
                if (acnt == m_len) begin
                    ph = 2;
                    mv = fval(int'(raddr), m_seed);
                end
            end
        end else if (!cs_n && !sclk && sclk_prev && ph == 2) begin
            if (di_oe !== 1'b0) oe_err++;
            mvx = mv ^ m_mask;
            if (oc == 0)       do_line = 1'b0;
            else if (oc <= 8)  do_line = mv[8-oc];
            else if (oc <= 15) do_line = mvx[oc-8];
            else               do_line = 1'b0;
            oc++;
        end
        sclk_prev = sclk;
        cs_prev   = cs_n;
    end

    // frame timing monitor, sampled away from the active edge
    int lc = 0, first_hi = 0;
    bit in_fr = 1'b0;
    always @(negedge clk) begin
        if (!cs_n) begin
            if (!in_fr) begin in_fr = 1'b1; lc = 0; first_hi = 0; end
            lc++;
            if (sclk && first_hi == 0) first_hi = lc;
        end else begin
            in_fr = 1'b0;
        end
    end

    int         frame_no  = 0;
    logic [7:0] last_exp  = 8'h00;
    bit         last_mism = 1'b0;

    task automatic run_frame(input int a, input int lreq, input bit dual);
        int   L, nb, n, ea;
        bit   corrupt, spurious;
        logic [7:0] exp;
        L        = (lreq < 2) ? 2 : ((lreq > 4) ? 4 : lreq);
        corrupt  = dual && (a % 3 == 0);
        spurious = (a % 4 == 1);
        frame_no++;
        m_seed = frame_no;
        m_len  = L;
        m_mask = corrupt ? 8'(1 << (a % 7 + 1)) : 8'h00;
        nb     = dual ? L + 17 : L + 10;
        ea     = a & ((1 << L) - 1);
        exp    = fval(ea, frame_no);

        n = 0;
        while (!req_ready && n < 200) begin @(negedge clk); n++; end
        chk(req_ready, "R10", int'(req_ready), 1);
        chk(rsp_data == last_exp, "R12", int'(rsp_data), int'(last_exp));
        chk(rsp_mismatch == last_mism, "R12", int'(rsp_mismatch), int'(last_mism));
        req_valid = 1'b1; req_addr = 4'(a); req_alen = 3'(lreq); req_dual = dual;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~4'(a); req_alen = 3'(lreq + 1); req_dual = ~dual;
        if (spurious) begin
            repeat (6) @(negedge clk);
            req_valid = 1'b1; req_addr = 4'(a) ^ 4'hF;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!rsp_done && n < 4000) begin @(negedge clk); n++; end
        chk(rsp_done, "R8", int'(rsp_done), 1);
        chk(cs_n == 1'b1, "R8", int'(cs_n), 1);
        chk(rsp_data == exp, "R6", int'(rsp_data), int'(exp));
        chk(rsp_mismatch == corrupt, "R7", int'(rsp_mismatch), int'(corrupt));
        chk(start_at == 1, "R4", start_at, 1);
        chk(int'(raddr) == ea, "R4", int'(raddr), ea);
        chk(rises == nb, "R8", rises, nb);
        chk(lc == nb * 2 * HALF, "R3", lc, nb * 2 * HALF);
        chk(first_hi == HALF + 1, "R2", first_hi, HALF + 1);
        chk(oe_err == 0, "R9", oe_err, 0);
        @(negedge clk);
        chk(!rsp_done, "R12", int'(rsp_done), 0);
        chk(rsp_data == exp, "R12", int'(rsp_data), int'(exp));
        if (spurious) begin
            for (int i = 0; i < GUARD_N + 4; i++) begin
                chk(cs_n == 1'b1, "R11", int'(cs_n), 1);
                @(negedge clk);
            end
        end
        last_exp  = exp;
        last_mism = corrupt;
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_alen = '0; req_dual = 1'b0;
        repeat (5) @(negedge clk);
        chk(cs_n == 1'b1, "R1", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1", int'(sclk), 0);
        chk(di_oe == 1'b0, "R1", int'(di_oe), 0);
        chk(rsp_done == 1'b0, "R1", int'(rsp_done), 0);
        chk(req_ready == 1'b0, "R1", int'(req_ready), 0);
        rst_n = 1'b1;
        repeat (GUARD_N - 1) @(negedge clk);
        chk(req_ready == 1'b0, "R1", int'(req_ready), 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < 8; l++)
                for (int a = 0; a < 16; a++)
                    run_frame(a, l, d[0]);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

endmodule